// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory Transfer Engine

This block moves one data word from a peripheral register into memory each time the peripheral raises its service request, without any work from the processor beyond a one-time setup. Software first loads a source address (the peripheral's data register) and a destination address (the memory word) through a small configuration write port. After reset these hold 0x8000 and 0x0001.

When the peripheral asks for service, the engine requests the system bus from the processor and waits for the grant. It then acknowledges the peripheral, reads the word at the source address, and writes that word to the destination address. It then drops its bus request and the peripheral acknowledge in the same cycle. It re-arms only after the processor has withdrawn its grant and the peripheral has let go of its request. If a new request appears while the old grant is still up, it is remembered and served once the engine is idle again.

The system bus port completes every access in one cycle, so the read data must be valid in the cycle the read strobe is high. The engine applies no back-pressure of its own. The processor throttles the engine only through the grant.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, bus request, peripheral acknowledge, read strobe, write strobe, bus address and write data are all zero, and the source and destination addresses are 0x8000 and 0x0001.
- R2: A high peripheral request sampled while idle raises the bus request on the next cycle.
- R3: While the bus request is up but no grant has been sampled, the read and write strobes stay low.
- R4: The cycle after a grant is sampled, the engine raises the peripheral acknowledge and the read strobe, with the source address on the bus.
- R5: The cycle after the read, the write strobe is high for one cycle, with the destination address on the bus and the word read in the previous cycle on the write data.
- R6: The cycle after the write, the bus request and the peripheral acknowledge fall together.
- R7: After a transfer, no new bus request is raised until the grant is low and the peripheral request has been seen low.
- R8: A request that rises again after being seen low, while the grant from the previous transfer is still high, is remembered even if it drops again. It raises the bus request the cycle after the engine returns to idle.
- R9: Whenever neither strobe is high, bus address and write data are zero.
- R10: A configuration write with select 0 sets the source address and with select 1 sets the destination address. The new value is used by the next transfer.
- R11: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 selects source address, 1 selects destination address |
| cfg_wdata | input | AW | Address value to write |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Acknowledge to the peripheral during the bus transfer |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| bus_addr | output | AW | System bus address |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the cycle bus_rd is high |

## Verification
A wrong sequencer state shows at the ports within one cycle, because every output is decoded directly from it. A stray or missing bus request, an acknowledge out of step with the strobes, or a strobe without a grant would each be visible in the very cycle after the faulty transition. Errors in the re-arm tracking show later. A lost pending request appears as a missing bus request two cycles after the grant falls. A missed check of the request going low appears as a bus request raised while the peripheral has held its request high the whole time. A bad captured word or address register shows only in the write cycle, as wrong data or a wrong address.

// File: rtl/dma_xfer_pkg.sv
`timescale 1ns/1ps
package dma_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ASK   = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } xfer_state_t;

  localparam int unsigned NUM_ADDR_REGS = 2;
  localparam logic SEL_SRC = 1'b0;
  localparam logic SEL_DST = 1'b1;
endpackage

// File: rtl/dma_xfer_cfg.sv
`timescale 1ns/1ps
module dma_xfer_cfg #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] RST_SRC = '0,
  parameter logic [AW-1:0] RST_DST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  import dma_xfer_pkg::*;

  logic [AW-1:0] addr_q [NUM_ADDR_REGS];

  for (genvar g = 0; g < NUM_ADDR_REGS; g++) begin : g_reg
    localparam logic [AW-1:0] INIT = (g == 0) ? RST_SRC : RST_DST;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= INIT;
      end else if (cfg_we && (cfg_sel == 1'(g))) begin
        addr_q[g] <= cfg_wdata;
      end
    end
  end

  assign src_addr = addr_q[SEL_SRC];
  assign dst_addr = addr_q[SEL_DST];
endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic per_req,
  input  logic bus_grant,
  output logic bus_req,
  output logic per_ack,
  output logic rd_en,
  output logic wr_en
);
  import dma_xfer_pkg::*;

  xfer_state_t state_q, state_d;
  logic        low_seen_q, low_seen_d;
  logic        pend_q, pend_d;
  logic        rearm_ok;

  assign rearm_ok = !bus_grant && (low_seen_q || !per_req);

  always_comb begin
    state_d    = state_q;
    low_seen_d = low_seen_q;
    pend_d     = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (per_req || pend_q) begin
          state_d = ST_ASK;
          pend_d  = 1'b0;
        end
      end
      ST_ASK: begin
        if (bus_grant) state_d = ST_READ;
      end
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: begin
        state_d    = ST_DONE;
        low_seen_d = 1'b0;
      end
      ST_DONE: begin
        if (rearm_ok) begin
          state_d    = ST_IDLE;
          low_seen_d = 1'b0;
        end else begin
          if (low_seen_q && per_req) pend_d = 1'b1;
          if (!per_req) low_seen_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      low_seen_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      low_seen_q <= low_seen_d;
      pend_q     <= pend_d;
    end
  end

  assign bus_req = (state_q == ST_ASK) || (state_q == ST_READ) || (state_q == ST_WRITE);
  assign per_ack = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign rd_en   = (state_q == ST_READ);
  assign wr_en   = (state_q == ST_WRITE);
endmodule

// File: rtl/dma_xfer_bus.sv
`timescale 1ns/1ps
module dma_xfer_bus #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (rd_en) begin
      word_q <= bus_rdata;
    end
  end

  always_comb begin
    bus_addr = '0;
    if (rd_en)      bus_addr = src_addr;
    else if (wr_en) bus_addr = dst_addr;
  end

  assign bus_wdata = wr_en ? word_q : '0;
  assign bus_rd    = rd_en;
  assign bus_wr    = wr_en;
endmodule

// File: rtl/dma_xfer_ctrl.sv
`timescale 1ns/1ps
module dma_xfer_ctrl #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] RST_SRC = AW'(16'h8000),
  parameter logic [AW-1:0] RST_DST = AW'(16'h0001)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          per_req,
  output logic          per_ack,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  logic [AW-1:0] src_addr, dst_addr;
  logic          rd_en, wr_en;

  dma_xfer_cfg #(.AW(AW), .RST_SRC(RST_SRC), .RST_DST(RST_DST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  dma_xfer_seq u_seq (
    .clk(clk), .rst_n(rst_n), .per_req(per_req), .bus_grant(bus_grant),
    .bus_req(bus_req), .per_ack(per_ack), .rd_en(rd_en), .wr_en(wr_en)
  );

  dma_xfer_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .src_addr(src_addr), .dst_addr(dst_addr), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata)
  );
endmodule

// File: rtl/dma_xfer_chk.sv
`timescale 1ns/1ps
module dma_xfer_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          per_ack,
  input logic          bus_req,
  input logic          bus_grant,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata
);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr) |-> (bus_addr == '0 && bus_wdata == '0));

  assert_grant_before_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> ($past(bus_grant) && $past(bus_req)));

  assert_ack_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (per_ack && bus_req));

  assert_write_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_wr && per_ack));

  assert_joint_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $fell(per_ack));
endmodule

bind dma_xfer_ctrl dma_xfer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .per_ack(per_ack), .bus_req(bus_req),
  .bus_grant(bus_grant), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata)
);

// File: tb/dma_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          per_req = 1'b0, bus_grant = 1'b0;
  logic          per_ack, bus_req, bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [DW-1:0] per_word = '0;

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  // reference model state
  int            m_state = 0;  // 0 idle 1 asking 2 read 3 write 4 release
  bit            m_seen = 0, m_pend = 0;
  logic [DW-1:0] m_word = '0;
  logic [AW-1:0] m_src = 16'h8000, m_dst = 16'h0001;

  always #2.5 clk = ~clk;

  // peripheral register answers reads at the configured source address
  assign bus_rdata = (bus_rd && bus_addr == m_src) ? per_word : '0;

  dma_xfer_ctrl u_dma_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .per_req(per_req), .per_ack(per_ack),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("bus_req",   32'(bus_req),   32'(m_state >= 1 && m_state <= 3));
    chk("per_ack",   32'(per_ack),   32'(m_state == 2 || m_state == 3));
    chk("bus_rd",    32'(bus_rd),    32'(m_state == 2));
    chk("bus_wr",    32'(bus_wr),    32'(m_state == 3));
    chk("bus_addr",  32'(bus_addr),  (m_state == 2) ? 32'(m_src) : (m_state == 3) ? 32'(m_dst) : 32'h0);
    chk("bus_wdata", 32'(bus_wdata), (m_state == 3) ? 32'(m_word) : 32'h0);
    chk("R11 strobe exclusion", 32'(bus_rd && bus_wr), 32'h0);
  endtask

  task automatic model_edge();
    if (cfg_we) begin
      if (cfg_sel) m_dst = cfg_wdata; else m_src = cfg_wdata;
    end
    case (m_state)
      0: if (per_req || m_pend) begin m_state = 1; m_pend = 0; end
      1: if (bus_grant) m_state = 2;
      2: begin m_word = per_word; m_state = 3; end
      3: begin m_state = 4; m_seen = 0; end
      default: begin
        if (!bus_grant && (m_seen || !per_req)) begin
          m_state = 0; m_seen = 0;
        end else begin
          if (m_seen && per_req) m_pend = 1;
          if (!per_req) m_seen = 1;
        end
      end
    endcase
  endtask

  task automatic step(input logic r, input logic g, input logic we = 1'b0,
                      input logic sel = 1'b0, input logic [AW-1:0] wd = '0);
    per_req = r; bus_grant = g; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    cur_tag = "R1";
    compare_all();
    step(0, 0);

    // R2/R3/R4/R5/R6: transfer with delayed grant from default addresses
    per_word = 8'h5A;
    cur_tag = "R2"; step(1, 0);
    cur_tag = "R3"; step(1, 0); step(1, 0); step(1, 0);
    cur_tag = "R4"; step(1, 1);
    chk("R4 read addr default 0x8000", 32'(bus_addr), 32'h8000);
    cur_tag = "R5"; step(1, 1);
    chk("R5 write addr default 0x0001", 32'(bus_addr), 32'h0001);
    chk("R5 written word", 32'(bus_wdata), 32'h5A);
    cur_tag = "R6"; step(1, 1);
    chk("R6 request and ack low", 32'({bus_req, per_ack}), 32'h0);

    // R7: req held high through grant removal must not re-arm
    cur_tag = "R7";
    step(1, 1); step(1, 1); step(1, 0); step(1, 0); step(1, 0);
    chk("R7 no new request while req still high", 32'(bus_req), 32'h0);
    step(0, 0); step(0, 0);

    // R10: reprogram addresses, transfer with immediate grant
    cur_tag = "R10";
    step(0, 0, 1'b1, 1'b0, 16'h1234);
    step(0, 0, 1'b1, 1'b1, 16'h00A0);
    per_word = 8'hC3;
    step(1, 1); step(1, 1);
    chk("R10 new source used", 32'(bus_addr), 32'h1234);
    step(1, 1);
    chk("R10 new destination used", 32'(bus_addr), 32'h00A0);
    chk("R10 word moved", 32'(bus_wdata), 32'hC3);
    step(1, 1);

    // R8: request re-raised under old grant, then dropped, still served
    cur_tag = "R8";
    step(0, 1); step(1, 1); step(0, 1); step(0, 0);
    chk("R8 idle before pending service", 32'(bus_req), 32'h0);
    step(0, 0);
    chk("R8 pending request served", 32'(bus_req), 32'h1);
    per_word = 8'h77;
    step(0, 1); step(0, 1);
    chk("R8 pending word written", 32'(bus_wdata), 32'h77);
    step(0, 1); step(0, 0);

    // R9: idle and configuration activity leave the bus quiet
    cur_tag = "R9";
    step(0, 0, 1'b1, 1'b0, 16'hFFFF);
    step(0, 0);
    chk("R9 quiet address", 32'(bus_addr), 32'h0);
    step(0, 1); step(0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule